// File: doc/BRIEF.md
# SPI Slave Memory-Access Port

This block lets an external SPI host read and write a 16-bit-addressed on-chip byte memory. Every transaction opens with a command byte, followed by a 16-bit start address. After that come as many data bytes as the host wants. Bit 7 of the command selects the direction. Each data byte goes to or comes from the next location in turn, because an internal access pointer advances by one after every byte. The host therefore sends the address only once per burst.

The port runs on the system clock. The chip select, serial clock and serial data pins pass through a two-stage synchronizer, and the block looks for edges on the synchronized signals. The serial clock must stay well below the system clock. The memory side is a single-cycle request port with a read latency of one cycle.

Firmware reaches the block through a small register file:
- a control register holding the enable bit and the interrupt flag;
- copies of the last command;
- copies of the last start address.

A transaction ends when chip select is released, and the flag is set at that point. Writes flagged as silent do not set it. Until the enable bit is set, the four shared pads carry an alternate function's output values and output enables.

Top module: `spi_port_top`

## Requirements
- R1: While the synchronized chip select (pad 0) is high, the data-out pad (pad 3) has its output enable low. Serial clock and data-in activity cause no memory access and no change to the command or address registers.
- R2: After chip select falls, bits are sampled on rising serial-clock edges, MSB first. The first 8 bits form the command byte and the next 16 bits form the start address (high byte first).
- R3: When command bit 7 is 1 (read), the block returns data bytes MSB first on pad 3, changing after falling serial-clock edges. The first byte comes from the start address.
- R4: When command bit 7 is 0 (write), every complete 8-bit data byte is written to memory. A trailing partial byte is discarded.
- R5: Consecutive data bytes in one transaction use consecutive addresses (start, start+1, ...), carrying across the low byte.
- R6: Register 1 holds the last received command byte. Registers 2 and 3 hold the low and high bytes of the last start address, and the auto-increment does not change them.
- R7: Releasing chip select sets the interrupt flag (register 0 bit 1), including for a command-only transaction. The flag is not set when the command was a write with bit 6 set.
- R8: A register write to address 0 with bit 1 = 0 clears the flag, and one with bit 1 = 1 leaves it unchanged. The irq_o output equals the flag.
- R9: Register 0 bit 0 is the enable bit. When it is 0, pad_o/pad_oe_o equal alt_o_i/alt_oe_i, the port sees chip select as high, and no memory access occurs. When it is 1, pads 0 to 2 are inputs (chip select, serial clock, data in) and pad 3 is the data-out pin.
- R10: After reset, all registers read 0, the flag is clear and the port is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | 4 | Pad input values (0 chip select, 1 serial clock, 2 data in) |
| pad_o | output | 4 | Pad output values |
| pad_oe_o | output | 4 | Pad output enables |
| alt_o_i | input | 4 | Alternate function output values |
| alt_oe_i | input | 4 | Alternate function output enables |
| mem_req_o | output | 1 | Memory access request, one cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions assume:
- the serial clock holds each level for several system cycles, so at most one memory request can occur per data byte;
- a memory request never repeats on consecutive cycles;
- the memory answers a read on the cycle after the request.

The stimulus uses a serial half-period of eight system clocks. It changes pads only on falling system-clock edges, and its memory model returns read data one cycle after each request. Chip select is held high for several cycles between transactions, so every deselect is seen by the synchronizer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned NPADS  = 4;
  localparam int unsigned PAD_CSN  = 0;
  localparam int unsigned PAD_SCK  = 1;
  localparam int unsigned PAD_MOSI = 2;
  localparam int unsigned PAD_MISO = 3;
  localparam int unsigned CMD_RD_BIT     = CMD_W - 1;
  localparam int unsigned CMD_SILENT_BIT = CMD_W - 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CMD    = 2'd1,
    REG_ADR_LO = 2'd2,
    REG_ADR_HI = 2'd3
  } reg_idx_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_port_pinmux.sv
module spi_port_pinmux
  import spi_port_pkg::*;
(
  input  logic             en_i,
  input  logic [NPADS-1:0] pad_i,
  output logic [NPADS-1:0] pad_o,
  output logic [NPADS-1:0] pad_oe_o,
  input  logic [NPADS-1:0] alt_o_i,
  input  logic [NPADS-1:0] alt_oe_i,
  input  logic             miso_i,
  input  logic             miso_oe_i,
  output logic             csn_o,
  output logic             sck_o,
  output logic             mosi_o
);
  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    if (p == PAD_MISO) begin : g_out
      assign pad_o[p]    = en_i ? miso_i    : alt_o_i[p];
      assign pad_oe_o[p] = en_i ? miso_oe_i : alt_oe_i[p];
    end else begin : g_in
      assign pad_o[p]    = en_i ? 1'b0 : alt_o_i[p];
      assign pad_oe_o[p] = en_i ? 1'b0 : alt_oe_i[p];
    end
  end

  // disabled port sees an idle bus
  assign csn_o  = en_i ? pad_i[PAD_CSN]  : 1'b1;
  assign sck_o  = en_i ? pad_i[PAD_SCK]  : 1'b0;
  assign mosi_o = en_i ? pad_i[PAD_MOSI] : 1'b0;
endmodule

// File: rtl/spi_port_frame.sv
module spi_port_frame
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              active_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              cmd_stb_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              addr_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              end_stb_o,
  output logic              end_irq_o
);
  localparam int unsigned HDR_BITS = CMD_W + ADDR_W;
  localparam int unsigned CNT_W    = $clog2(HDR_BITS + 1);
  localparam int unsigned DCNT_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0]  HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0]  HDR_DONE = CNT_W'(HDR_BITS);
  localparam logic [DCNT_W-1:0] DAT_LAST = DCNT_W'(DATA_W - 1);

  logic                sck_q, csn_q;
  logic                sck_rise, sck_fall, cs_fall;
  logic [CNT_W-1:0]    hdr_cnt_q;
  logic [DCNT_W-1:0]   dcnt_q;
  logic [HDR_BITS-1:0] hdr_sr_q, hdr_nxt;
  logic [DATA_W-1:0]   dat_sr_q, dat_nxt;
  logic [DATA_W-1:0]   tx_sr_q;
  logic                miso_q;
  logic [CMD_W-1:0]    cmd_q;
  logic                cmd_vld_q;
  logic [ADDR_W-1:0]   acc_addr_q;
  logic                req_q, we_q, rd_pend_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                cmd_stb_q, addr_stb_q;
  logic                is_read;

  assign sck_rise = sck_i & ~sck_q;
  assign sck_fall = ~sck_i & sck_q;
  assign cs_fall  = ~csn_i & csn_q;
  assign hdr_nxt  = {hdr_sr_q[HDR_BITS-2:0], mosi_i};
  assign dat_nxt  = {dat_sr_q[DATA_W-2:0], mosi_i};
  assign is_read  = cmd_q[CMD_RD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      csn_q      <= 1'b1;
      hdr_cnt_q  <= '0;
      dcnt_q     <= '0;
      hdr_sr_q   <= '0;
      dat_sr_q   <= '0;
      tx_sr_q    <= '0;
      miso_q     <= 1'b0;
      cmd_q      <= '0;
      cmd_vld_q  <= 1'b0;
      acc_addr_q <= '0;
      req_q      <= 1'b0;
      we_q       <= 1'b0;
      rd_pend_q  <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      cmd_stb_q  <= 1'b0;
      addr_stb_q <= 1'b0;
    end else begin
      sck_q      <= sck_i;
      csn_q      <= csn_i;
      req_q      <= 1'b0;
      cmd_stb_q  <= 1'b0;
      addr_stb_q <= 1'b0;
      rd_pend_q  <= req_q & ~we_q;
      if (cs_fall) cmd_vld_q <= 1'b0;
      if (csn_i) begin
        hdr_cnt_q <= '0;
        dcnt_q    <= '0;
        hdr_sr_q  <= '0;
        dat_sr_q  <= '0;
        tx_sr_q   <= '0;
        miso_q    <= 1'b0;
        rd_pend_q <= 1'b0;
      end else begin
        // fetched byte lands between a rising and the next falling edge
        if (rd_pend_q) begin
          tx_sr_q <= mem_rdata_i;
        end else if (sck_fall) begin
          miso_q  <= tx_sr_q[DATA_W-1];
          tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
        end
        if (sck_rise) begin
          if (hdr_cnt_q != HDR_DONE) begin
            hdr_sr_q  <= hdr_nxt;
            hdr_cnt_q <= hdr_cnt_q + 1'b1;
            if (hdr_cnt_q == CMD_LAST) begin
              cmd_q     <= hdr_nxt[CMD_W-1:0];
              cmd_vld_q <= 1'b1;
              cmd_stb_q <= 1'b1;
            end
            if (hdr_cnt_q == HDR_LAST) begin
              addr_stb_q <= 1'b1;
              acc_addr_q <= hdr_nxt[ADDR_W-1:0];
              if (is_read) begin
                req_q      <= 1'b1;
                we_q       <= 1'b0;
                addr_q     <= hdr_nxt[ADDR_W-1:0];
                acc_addr_q <= hdr_nxt[ADDR_W-1:0] + ADDR_W'(1);
              end
            end
          end else begin
            dat_sr_q <= dat_nxt;
            dcnt_q   <= (dcnt_q == DAT_LAST) ? '0 : dcnt_q + 1'b1;
            if (dcnt_q == DAT_LAST) begin
              // write: store this byte; read: prefetch the next one
              req_q      <= 1'b1;
              we_q       <= ~is_read;
              addr_q     <= acc_addr_q;
              wdata_q    <= dat_nxt;
              acc_addr_q <= acc_addr_q + ADDR_W'(1);
            end
          end
        end
      end
    end
  end

  assign miso_o      = miso_q;
  assign active_o    = ~csn_i;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign cmd_stb_o   = cmd_stb_q;
  assign cmd_o       = cmd_q;
  assign addr_stb_o  = addr_stb_q;
  assign addr_o      = hdr_sr_q[ADDR_W-1:0];
  assign end_stb_o   = csn_i & ~csn_q;
  assign end_irq_o   = ~(cmd_vld_q & ~is_read & cmd_q[CMD_SILENT_BIT]);
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              cmd_stb_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              addr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              end_stb_i,
  input  logic              end_irq_i,
  output logic              en_o,
  output logic              flag_o
);
  logic              en_q, flag_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ctrl_wr;

  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= reg_wdata_i[CTRL_EN_BIT];
      // a hardware set wins over a simultaneous clear
      if (end_stb_i && end_irq_i)                 flag_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata_i[CTRL_FLAG_BIT]) flag_q <= 1'b0;
      if (cmd_stb_i)  cmd_q  <= cmd_i;
      if (addr_stb_i) addr_q <= addr_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT]   = en_q;
        reg_rdata_o[CTRL_FLAG_BIT] = flag_q;
      end
      REG_CMD:    reg_rdata_o = cmd_q;
      REG_ADR_LO: reg_rdata_o = addr_q[7:0];
      REG_ADR_HI: reg_rdata_o = addr_q[15:8];
      default:    reg_rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/spi_port_top.sv
module spi_port_top
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPADS-1:0]  pad_i,
  output logic [NPADS-1:0]  pad_o,
  output logic [NPADS-1:0]  pad_oe_o,
  input  logic [NPADS-1:0]  alt_o_i,
  input  logic [NPADS-1:0]  alt_oe_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o
);
  logic              spi_en;
  logic              raw_csn, raw_sck, raw_mosi;
  logic [2:0]        sync_q;
  logic              miso, active;
  logic              cmd_stb, addr_stb, end_stb, end_irq;
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;

  spi_port_pinmux u_pinmux (
    .en_i      (spi_en),
    .pad_i     (pad_i),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o),
    .alt_o_i   (alt_o_i),
    .alt_oe_i  (alt_oe_i),
    .miso_i    (miso),
    .miso_oe_i (active),
    .csn_o     (raw_csn),
    .sck_o     (raw_sck),
    .mosi_o    (raw_mosi)
  );

  spi_port_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({raw_mosi, raw_sck, raw_csn}),
    .q_o    (sync_q)
  );

  spi_port_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csn_i       (sync_q[0]),
    .sck_i       (sync_q[1]),
    .mosi_i      (sync_q[2]),
    .miso_o      (miso),
    .active_o    (active),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .cmd_stb_o   (cmd_stb),
    .cmd_o       (cmd),
    .addr_stb_o  (addr_stb),
    .addr_o      (addr),
    .end_stb_o   (end_stb),
    .end_irq_o   (end_irq)
  );

  spi_port_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cmd_stb_i   (cmd_stb),
    .cmd_i       (cmd),
    .addr_stb_i  (addr_stb),
    .addr_i      (addr),
    .end_stb_i   (end_stb),
    .end_irq_i   (end_irq),
    .en_o        (spi_en),
    .flag_o      (irq_o)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [NPADS-1:0] pad_i,
  input logic [NPADS-1:0] pad_o,
  input logic [NPADS-1:0] pad_oe_o,
  input logic [NPADS-1:0] alt_o_i,
  input logic [NPADS-1:0] alt_oe_i,
  input logic             mem_req_o,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             end_stb_i,
  input logic             irq_o
);
  logic [2:0] cs_hi_cnt, dis_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_hi_cnt <= '0;
      dis_cnt   <= '0;
    end else begin
      cs_hi_cnt <= !pad_i[PAD_CSN] ? '0 : (cs_hi_cnt == 3'd4 ? cs_hi_cnt : cs_hi_cnt + 1'b1);
      dis_cnt   <= en_i ? '0 : (dis_cnt == 3'd4 ? dis_cnt : dis_cnt + 1'b1);
    end
  end

  // R1
  hiz_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cs_hi_cnt == 3'd4) |-> !pad_oe_o[PAD_MISO]);

  // R9
  alt_mux_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (pad_o == alt_o_i && pad_oe_o == alt_oe_i));

  // R9
  no_access_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_cnt == 3'd4) |-> !mem_req_o);

  // R5
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R7
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(end_stb_i));

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_we_i && reg_addr_i == 2'd0 && !reg_wdata_i[CTRL_FLAG_BIT]));
endmodule

bind spi_port_top spi_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (spi_en),
  .pad_i       (pad_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .alt_o_i     (alt_o_i),
  .alt_oe_i    (alt_oe_i),
  .mem_req_o   (mem_req_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .end_stb_i   (end_stb),
  .irq_o       (irq_o)
);

// File: tb/spi_port_top_tb_top.sv
`timescale 1ns/1ps
module spi_port_top_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pad_i = 4'b0001;
  logic [3:0]  pad_o, pad_oe_o;
  logic [3:0]  alt_o = '0, alt_oe = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  int acc_cnt = 0;
  logic [7:0] bmem [int];
  logic [7:0] exp_mem [int];
  logic [7:0] tx_q [$];
  logic [7:0] rx_q [$];
  bit   exp_en = 0, exp_flag = 0, hold = 1, done = 0;
  int   cs_hi = 0;

  always #2 clk = ~clk;

  spi_port_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
    .alt_o_i(alt_o), .alt_oe_i(alt_oe), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      acc_cnt++;
      if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    end
  end

  always @(negedge clk) begin
    alt_o  <= alt_o + 4'd1;
    alt_oe <= alt_oe ^ 4'b1010;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    cs_hi = pad_i[0] ? cs_hi + 1 : 0;
    if (rst_n && !hold) begin
      chk("R8 irq", irq, exp_flag);
      if (!exp_en) chk("R9 mux", {pad_o, pad_oe_o}, {alt_o, alt_oe});
      else if (cs_hi > 4) chk("R1 hiz", pad_oe_o[3], 1'b0);
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    hold = 1;
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 2'd0) begin
      exp_en = d[0];
      if (!d[1]) exp_flag = 0;
    end
    hold = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  // shifts tx_q out, then extra bits of 1s; records data-out bytes in rx_q
  task automatic xfer(input int extra);
    logic [7:0] b, r;
    hold = 1;
    rx_q.delete();
    @(negedge clk); pad_i[0] = 0;
    repeat (HALF) @(negedge clk);
    foreach (tx_q[i]) begin
      b = tx_q[i];
      for (int k = 7; k >= 0; k--) begin
        pad_i[2] = b[k];
        repeat (HALF) @(negedge clk);
        r[k] = pad_o[3];
        pad_i[1] = 1;
        repeat (HALF) @(negedge clk);
        pad_i[1] = 0;
      end
      rx_q.push_back(r);
    end
    for (int k = 0; k < extra; k++) begin
      pad_i[2] = 1;
      repeat (HALF) @(negedge clk); pad_i[1] = 1;
      repeat (HALF) @(negedge clk); pad_i[1] = 0;
    end
    repeat (HALF) @(negedge clk);
    pad_i[0] = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic end_model(input logic [7:0] cmd, input bit cmd_done);
    if (exp_en && !(cmd_done && !cmd[7] && cmd[6])) exp_flag = 1;
    hold = 0;
  endtask

  task automatic chk_regs(input string req, input logic [7:0] c, input logic [15:0] a);
    logic [7:0] v;
    reg_rd(2'd1, v); chk({req, " cmd reg"}, v, c);
    reg_rd(2'd2, v); chk({req, " addr lo"}, v, a[7:0]);
    reg_rd(2'd3, v); chk({req, " addr hi"}, v, a[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    reg_rd(2'd0, v); chk("R10 ctrl", v, 8'h00);
    chk_regs("R10", 8'h00, 16'h0000);
    chk("R10 irq", irq, 1'b0);
    hold = 0;
    repeat (4) @(negedge clk);

    reg_wr(2'd0, 8'h03);
    reg_rd(2'd0, v); chk("R9 enable", v, 8'h01);

    // R1: clock/data activity while deselected
    hold = 1; n0 = acc_cnt;
    for (int i = 0; i < 6; i++) begin
      pad_i[1] = ~pad_i[1]; pad_i[2] = ~pad_i[2];
      repeat (3) @(negedge clk);
      chk("R1 oe idle", pad_oe_o[3], 1'b0);
    end
    pad_i[1] = 0; pad_i[2] = 0;
    repeat (4) @(negedge clk);
    chk("R1 no access", acc_cnt, n0);
    hold = 0;
    chk_regs("R1", 8'h00, 16'h0000);
    chk("R1 flag", irq, 1'b0);

    // R2 R4 R5 write burst across low byte
    tx_q = '{8'h00, 8'h12, 8'hFE, 8'hA5, 8'h3C, 8'h7E};
    xfer(0); end_model(8'h00, 1);
    exp_mem[32'h12FE] = 8'hA5; exp_mem[32'h12FF] = 8'h3C; exp_mem[32'h1300] = 8'h7E;
    foreach (exp_mem[a]) chk("R4 R5 mem", bmem.exists(a) ? bmem[a] : 8'hxx, exp_mem[a]);
    chk_regs("R6", 8'h00, 16'h12FE);
    chk("R7 flag set", irq, 1'b1);

    // R8: writing 1 keeps, writing 0 clears
    reg_wr(2'd0, 8'h03);
    chk("R8 keep", irq, 1'b1);
    reg_wr(2'd0, 8'h01);
    chk("R8 clear", irq, 1'b0);

    // R3 R5 read burst
    bmem[32'h1301] = 8'h99; exp_mem[32'h1301] = 8'h99;
    tx_q = '{8'h80, 8'h12, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(0); end_model(8'h80, 1);
    chk("R3 byte0", rx_q[3], exp_mem[32'h12FE]);
    chk("R3 R5 byte1", rx_q[4], exp_mem[32'h12FF]);
    chk("R5 byte2", rx_q[5], exp_mem[32'h1300]);
    chk("R5 byte3", rx_q[6], exp_mem[32'h1301]);
    chk_regs("R6", 8'h80, 16'h12FE);
    chk("R7 read flag", irq, 1'b1);
    reg_wr(2'd0, 8'h01);

    // R7 silent write
    tx_q = '{8'h40, 8'h00, 8'h40, 8'h11};
    xfer(0); end_model(8'h40, 1);
    chk("R4 silent mem", bmem.exists(32'h40) ? bmem[32'h40] : 8'hxx, 8'h11);
    chk("R7 silent no flag", irq, 1'b0);
    chk_regs("R6", 8'h40, 16'h0040);

    // R4 partial byte discarded
    n0 = acc_cnt;
    tx_q = '{8'h00, 8'h00, 8'h50, 8'h22};
    xfer(3); end_model(8'h00, 1);
    chk("R4 one write", acc_cnt - n0, 1);
    chk("R4 partial", bmem.exists(32'h51), 1'b0);
    chk("R4 full", bmem.exists(32'h50) ? bmem[32'h50] : 8'hxx, 8'h22);
    reg_wr(2'd0, 8'h01);

    // R7 command only
    tx_q = '{8'h81};
    xfer(0); end_model(8'h81, 1);
    chk("R7 cmd only flag", irq, 1'b1);
    chk_regs("R6 cmd only", 8'h81, 16'h0050);

    // R9 disabled: port ignores traffic
    reg_wr(2'd0, 8'h00);
    n0 = acc_cnt;
    tx_q = '{8'h00, 8'h00, 8'h60, 8'h33};
    xfer(0); end_model(8'h00, 1);
    chk("R9 no access", acc_cnt, n0);
    chk("R9 no flag", irq, 1'b0);
    chk_regs("R9", 8'h81, 16'h0050);

    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule